// File: doc/BRIEF.md
# Tenant-Partitioned Dependency Token Queue

This block holds the dependency tokens passed between the load, compute and store stages of a decoupled access-execute accelerator that several mutually distrusting tenants share at the same time. One physical token store is split into four private sections, one for each tenant. Every push and every pop carries a tenant number, and that number alone selects the section it acts on. As a result, no tenant can fill, drain or overwrite the tokens of another tenant.

Each section has its own write pointer, read pointer and occupancy count, and its own usable depth. The depth can be changed at runtime through a configuration port. Each tenant sees its own full, empty and sticky error flags. A driver sets the depth of each tenant before that tenant starts issuing tokens. The execution stages then push and pop freely and read only their own flags.

Top module: `dq_tenant_queue`

## Requirements
- R1: The store holds 16 tokens of 8 bits each, split into four fixed sections of 4 entries. After reset, every tenant is empty and not full, has no error, and has a configured depth of 4.
- R2: A push is appended to the section named by `pushTenant`. While the section named by `popTenant` holds tokens, `popData` shows its oldest token in the same cycle. A pop removes that token, so each tenant gets its own tokens back in push order.
- R3: A push, pop or configuration write aimed at one tenant never changes the full, empty or error flags of any other tenant, nor the order or values of the tokens that other tenant later reads.
- R4: `full[t]` is 1 exactly when tenant t holds as many tokens as its configured depth, even when that depth is smaller than its 4-entry section. `empty[t]` is 1 exactly when tenant t holds no tokens.
- R5: A push to a full tenant, or a pop from an empty tenant, is dropped. It sets `err[t]` for that tenant only, and `err[t]` stays at 1 until reset.
- R6: A configuration write is accepted only if the addressed tenant is empty at the start of that cycle. Otherwise it is ignored and the old depth stays in force.
- R7: A configuration write with depth 0, or with depth greater than 4, is rejected and the old depth is kept. Since every accepted depth fits inside its own section, the depths can never add up to more than the 16-entry store.
- R8: When a push and a pop hit the same tenant in one cycle, both are judged on the occupancy at the start of the cycle. A push to a full tenant is dropped even if a pop happens in the same cycle. A pop from an empty tenant is dropped even if a push happens in the same cycle.
- R9: The read and write pointers of each tenant wrap at the configured depth, so token order is kept across many wraps with a depth smaller than the section.
- R10: An accepted configuration write and a push to the same, previously empty, tenant in the same cycle both take effect. The token is kept under the new depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push request |
| pushTenant | input | 2 | Tenant that the push is aimed at |
| pushData | input | 8 | Token to push |
| popValid | input | 1 | Pop request |
| popTenant | input | 2 | Tenant that the pop is aimed at, and whose head token appears on popData |
| popData | output | 8 | Oldest token of the popTenant section (combinational) |
| cfgValid | input | 1 | Depth configuration write |
| cfgTenant | input | 2 | Tenant whose depth is being written |
| cfgDepth | input | 3 | New usable depth, accepted for values 1 to 4 |
| full | output | 4 | Full flag of each tenant |
| empty | output | 4 | Empty flag of each tenant |
| err | output | 4 | Sticky overflow/underflow flag of each tenant |

## Verification
A push and a pop can reach the same tenant in the same cycle, and so can a configuration write and a push. The bench builds both cases on purpose. It fills a tenant to its depth and then pushes and pops it at once. It pops an empty tenant while pushing to it. It reprograms an empty tenant while pushing its first token. A behavioural model then judges the result. The model decides every acceptance from the occupancy at the start of the cycle, keeps one queue per tenant, and is compared against every flag and every popped token on each clock. A pseudo-random phase then mixes all three operations across tenants.

// File: rtl/dq_pkg.sv
package dq_pkg;
  parameter int NUM_TEN     = 4;
  parameter int TOTAL_DEPTH = 16;
  parameter int TOK_W       = 8;

  localparam int SECT   = TOTAL_DEPTH / NUM_TEN;
  localparam int TEN_W  = $clog2(NUM_TEN);
  localparam int PTR_W  = $clog2(SECT);
  localparam int CNT_W  = $clog2(SECT + 1);
  localparam int ADDR_W = $clog2(TOTAL_DEPTH);

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } strobe_t;
endpackage

// File: rtl/dq_store.sv
module dq_store
  import dq_pkg::*;
(
  input  logic             clk,
  input  strobe_t          strobe,
  input  logic [TOK_W-1:0] pushData,
  output logic [TOK_W-1:0] popData
);
  logic [TOK_W-1:0] mem [TOTAL_DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[strobe.wrAddr] <= pushData;
  end

  assign popData = mem[strobe.rdAddr];
endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  logic [TEN_W-1:0]   pushTenant,
  input  logic               popValid,
  input  logic [TEN_W-1:0]   popTenant,
  input  logic               cfgValid,
  input  logic [TEN_W-1:0]   cfgTenant,
  input  logic [CNT_W-1:0]   cfgDepth,
  output strobe_t            strobe,
  output logic [NUM_TEN-1:0] full,
  output logic [NUM_TEN-1:0] empty,
  output logic [NUM_TEN-1:0] err
);
  logic [PTR_W-1:0]   wrBase [NUM_TEN];
  logic [PTR_W-1:0]   rdHead [NUM_TEN];
  logic [NUM_TEN-1:0] pushOk;

  for (genvar t = 0; t < NUM_TEN; t++) begin : g_ten
    logic [PTR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
    logic [CNT_W-1:0] count, depth, depthNext, wrInc, rdInc;
    logic             errQ;
    logic             pushHit, popHit, cfgHit, isEmpty, isFull, popOk, cfgOk;

    always_comb begin
      pushHit   = pushValid && (pushTenant == TEN_W'(t));
      popHit    = popValid && (popTenant == TEN_W'(t));
      cfgHit    = cfgValid && (cfgTenant == TEN_W'(t));
      isEmpty   = (count == '0);
      isFull    = (count == depth);
      pushOk[t] = pushHit && !isFull;
      popOk     = popHit && !isEmpty;
      cfgOk     = cfgHit && isEmpty && (cfgDepth != '0) && (cfgDepth <= CNT_W'(SECT));
      depthNext = cfgOk ? cfgDepth : depth;
      wrBase[t] = cfgOk ? '0 : wrPtr;
      wrInc     = CNT_W'(wrBase[t]) + CNT_W'(1);
      wrNext    = pushOk[t] ? ((wrInc >= depthNext) ? '0 : wrInc[PTR_W-1:0]) : wrBase[t];
      rdInc     = CNT_W'(rdPtr) + CNT_W'(1);
      rdNext    = popOk ? ((rdInc >= depth) ? '0 : rdInc[PTR_W-1:0])
                        : (cfgOk ? '0 : rdPtr);
      rdHead[t] = rdPtr;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
        depth <= CNT_W'(SECT);
        errQ  <= 1'b0;
      end else begin
        wrPtr <= wrNext;
        rdPtr <= rdNext;
        count <= count + CNT_W'(pushOk[t]) - CNT_W'(popOk);
        depth <= depthNext;
        errQ  <= errQ | (pushHit && isFull) | (popHit && isEmpty);
      end
    end

    assign full[t]  = isFull;
    assign empty[t] = isEmpty;
    assign err[t]   = errQ;
  end

  always_comb begin
    strobe.wrEn   = |pushOk;
    strobe.wrAddr = ADDR_W'(pushTenant) * ADDR_W'(SECT) + ADDR_W'(wrBase[pushTenant]);
    strobe.rdAddr = ADDR_W'(popTenant) * ADDR_W'(SECT) + ADDR_W'(rdHead[popTenant]);
  end
endmodule

// File: rtl/dq_tenant_queue.sv
module dq_tenant_queue
  import dq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  logic [TEN_W-1:0]   pushTenant,
  input  logic [TOK_W-1:0]   pushData,
  input  logic               popValid,
  input  logic [TEN_W-1:0]   popTenant,
  output logic [TOK_W-1:0]   popData,
  input  logic               cfgValid,
  input  logic [TEN_W-1:0]   cfgTenant,
  input  logic [CNT_W-1:0]   cfgDepth,
  output logic [NUM_TEN-1:0] full,
  output logic [NUM_TEN-1:0] empty,
  output logic [NUM_TEN-1:0] err
);
  strobe_t strobe;

  dq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushTenant(pushTenant),
    .popValid(popValid), .popTenant(popTenant),
    .cfgValid(cfgValid), .cfgTenant(cfgTenant), .cfgDepth(cfgDepth),
    .strobe(strobe), .full(full), .empty(empty), .err(err)
  );

  dq_store u_store (
    .clk(clk), .strobe(strobe), .pushData(pushData), .popData(popData)
  );
endmodule

// File: rtl/dq_tenant_queue_chk.sv
module dq_tenant_queue_chk
  import dq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               pushValid,
  input logic [TEN_W-1:0]   pushTenant,
  input logic               popValid,
  input logic [TEN_W-1:0]   popTenant,
  input logic [NUM_TEN-1:0] full,
  input logic [NUM_TEN-1:0] empty,
  input logic [NUM_TEN-1:0] err
);
  // R4: a configured depth is at least one, so no tenant is full and empty at once
  a_r4_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (full & empty) == '0);

  // R5: error bits never clear once set
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((err & $past(err)) == $past(err)));

  a_r5_overflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && full[pushTenant]) |=> err[$past(pushTenant)]);

  a_r5_underflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && empty[popTenant]) |=> err[$past(popTenant)]);

  for (genvar t = 0; t < NUM_TEN; t++) begin : g_iso
    // R3: a tenant that is not addressed keeps its flags
    a_r3_isolated_flags: assert property (@(posedge clk) disable iff (!rstN)
      (!(pushValid && pushTenant == TEN_W'(t)) && !(popValid && popTenant == TEN_W'(t)))
      |=> ($stable(full[t]) && $stable(empty[t]) && $stable(err[t])));

    // R2: a push that is not matched by a pop leaves the tenant non-empty
    a_r2_push_fills: assert property (@(posedge clk) disable iff (!rstN)
      (pushValid && pushTenant == TEN_W'(t) && empty[t] &&
       !(popValid && popTenant == TEN_W'(t))) |=> !empty[t]);
  end
endmodule

bind dq_tenant_queue dq_tenant_queue_chk u_chk (
  .clk(clk), .rstN(rstN),
  .pushValid(pushValid), .pushTenant(pushTenant),
  .popValid(popValid), .popTenant(popTenant),
  .full(full), .empty(empty), .err(err)
);

// File: tb/sim_dq_tenant_queue.sv
`timescale 1ns/1ps
module sim_dq_tenant_queue;
  import dq_pkg::*;

  logic               clk = 1'b0;
  logic               rstN;
  logic               pushValid, popValid, cfgValid;
  logic [TEN_W-1:0]   pushTenant, popTenant, cfgTenant;
  logic [TOK_W-1:0]   pushData, popData;
  logic [CNT_W-1:0]   cfgDepth;
  logic [NUM_TEN-1:0] full, empty, err;

  always #2 clk = ~clk;

  dq_tenant_queue u0 (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushTenant(pushTenant), .pushData(pushData),
    .popValid(popValid), .popTenant(popTenant), .popData(popData),
    .cfgValid(cfgValid), .cfgTenant(cfgTenant), .cfgDepth(cfgDepth),
    .full(full), .empty(empty), .err(err)
  );

  logic [TOK_W-1:0] mq [NUM_TEN][$];
  int               mDepth [NUM_TEN];
  logic [NUM_TEN-1:0] mErr;
  int vectors = 0;
  int misses  = 0;
  logic finished = 1'b0;

  task automatic checkFlags(input string tag);
    for (int t = 0; t < NUM_TEN; t++) begin
      logic ef, ee;
      ef = (mq[t].size() == mDepth[t]);
      ee = (mq[t].size() == 0);
      vectors++;
      if (full[t] !== ef || empty[t] !== ee || err[t] !== mErr[t]) begin
        misses++;
        $display("FAIL %s tenant %0d full/empty/err actual %b%b%b expected %b%b%b",
                 tag, t, full[t], empty[t], err[t], ef, ee, mErr[t]);
      end
    end
  endtask

  task automatic step(input logic pv, input int pt, input int pd,
                      input logic ov, input int ot,
                      input logic cv, input int ct, input int cd, input string tag);
    logic pushOk, popOk, cfgOk;
    pushValid  = pv; pushTenant = TEN_W'(pt); pushData = TOK_W'(pd);
    popValid   = ov; popTenant  = TEN_W'(ot);
    cfgValid   = cv; cfgTenant  = TEN_W'(ct); cfgDepth = CNT_W'(cd);
    #1;
    pushOk = pv && (mq[pt].size() < mDepth[pt]);
    popOk  = ov && (mq[ot].size() > 0);
    cfgOk  = cv && (mq[ct].size() == 0) && cd >= 1 && cd <= SECT;
    if (popOk) begin
      vectors++;
      if (popData !== mq[ot][0]) begin
        misses++;
        $display("FAIL %s pop tenant %0d data actual %h expected %h",
                 tag, ot, popData, mq[ot][0]);
      end
    end
    if (pv && !pushOk) mErr[pt] = 1'b1;
    if (ov && !popOk)  mErr[ot] = 1'b1;
    if (popOk)  void'(mq[ot].pop_front());
    if (pushOk) mq[pt].push_back(TOK_W'(pd));
    if (cfgOk)  mDepth[ct] = cd;
    @(posedge clk);
    @(negedge clk);
    pushValid = 1'b0; popValid = 1'b0; cfgValid = 1'b0;
    checkFlags(tag);
  endtask

  task automatic push(input int t, input int d, input string tag);
    step(1'b1, t, d, 1'b0, 0, 1'b0, 0, 0, tag);
  endtask
  task automatic pop(input int t, input string tag);
    step(1'b0, 0, 0, 1'b1, t, 1'b0, 0, 0, tag);
  endtask
  task automatic cfg(input int t, input int d, input string tag);
    step(1'b0, 0, 0, 1'b0, 0, 1'b1, t, d, tag);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rstN = 1'b0;
    pushValid = 1'b0; popValid = 1'b0; cfgValid = 1'b0;
    pushTenant = '0; popTenant = '0; cfgTenant = '0; pushData = '0; cfgDepth = '0;
    for (int t = 0; t < NUM_TEN; t++) mDepth[t] = SECT;
    mErr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkFlags("R1 reset");

    // R2: routing and order for two tenants, interleaved
    push(0, 8'h11, "R2"); push(2, 8'h21, "R2"); push(0, 8'h12, "R2");
    push(0, 8'h13, "R2"); push(2, 8'h22, "R2");
    pop(2, "R2"); pop(0, "R2"); pop(0, "R2"); pop(2, "R2"); pop(0, "R2");

    // R4: fill tenant 1 to its default depth
    for (int i = 0; i < SECT; i++) push(1, 8'h40 + i, "R4");
    // R5: overflow on tenant 1, underflow on tenant 3
    push(1, 8'hEE, "R5 overflow");
    pop(3, "R5 underflow");
    // R6: depth write to a non-empty tenant is ignored
    cfg(1, 2, "R6 ignored");
    pop(1, "R6"); push(1, 8'h50, "R6 old depth still 4");
    for (int i = 0; i < SECT; i++) pop(1, "R6 drain");
    cfg(1, 2, "R6 accepted");
    push(1, 8'h61, "R4 small depth"); push(1, 8'h62, "R4 full at 2");

    // R7: out-of-range depths rejected on empty tenant 0
    cfg(0, 0, "R7 zero"); cfg(0, SECT + 1, "R7 too big");
    for (int i = 0; i < SECT; i++) push(0, 8'h70 + i, "R7 depth kept");
    // R8: simultaneous push and pop on a full tenant
    step(1'b1, 0, 8'h7F, 1'b1, 0, 1'b0, 0, 0, "R8 full push+pop");
    // R8: simultaneous push and pop on an empty tenant
    step(1'b1, 3, 8'h31, 1'b1, 3, 1'b0, 0, 0, "R8 empty push+pop");
    step(1'b1, 3, 8'h32, 1'b1, 3, 1'b0, 0, 0, "R8 steady push+pop");

    // R9: wrap with depth 3 on tenant 2
    cfg(2, 3, "R9 cfg");
    for (int i = 0; i < 12; i++) begin
      push(2, 8'h90 + i, "R9");
      if (i % 2 == 1) begin pop(2, "R9"); pop(2, "R9"); end
    end
    while (mq[2].size() > 0) pop(2, "R9 drain");

    // R10: config and push in the same cycle on empty tenant 2
    step(1'b1, 2, 8'hA1, 1'b0, 0, 1'b1, 2, 1, "R10");
    push(2, 8'hA2, "R10 overflow at depth 1");
    pop(2, "R10");

    // R3: mixed traffic across tenants
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], int'(lfsr[2:1]), int'(lfsr[15:8]), lfsr[3], int'(lfsr[5:4]),
           lfsr[9:6] == 4'hF, int'(lfsr[11:10]), int'(lfsr[14:12]), "R3");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule